// File: doc/BRIEF.md
# Dual Non-Retriggerable Pulse Generator with Clear

This block turns trigger events on asynchronous control lines into single output pulses of a programmed length, counted in clock cycles. It holds two identical, fully independent channels. Each channel has an active-low trigger line, an active-high trigger line and an active-low clear line. It drives a true output and its exact complement. Every control line passes through a two-stage synchroniser, and edges are found by comparing each synchronised sample with the one before it.

A pulse can start from a falling edge of the active-low trigger, from a rising edge of the active-high trigger, or from the release of clear, which only counts when the high trigger went up while clear was still asserted. Once a pulse is running it cannot be restarted or stretched. Its length is fixed by the width value captured at the moment it starts. Clear forces the output low and ends any pulse early.

Latency convention: a line that changes between two clock edges is captured at the next edge (edge n). Its effect on the outputs is visible after edge n+2.

Top module: `dual_oneshot`

## Requirements
- R1: With the high trigger high and clear high, a falling edge on the low trigger starts a pulse. The true output goes high after the third clock edge following the change.
- R2: With the low trigger low and clear high, a rising edge on the high trigger starts a pulse.
- R3: While clear is low, the true output is held at 0 and the complement at 1, whatever the trigger lines do.
- R4: Taking clear low during a pulse ends it after the third clock edge following the change, before its programmed length has run out.
- R5: A rising edge on clear starts a pulse only if three conditions all hold: the low trigger is low, the high trigger is high, and the high trigger rose while clear was low and has not fallen since. A fall of the high trigger cancels that record, and so does issuing a pulse.
- R6: While a pulse is high, edges on either trigger line are ignored, and the pulse length is unchanged.
- R7: With the low trigger held high, or the high trigger held low, no pulse starts and the true output stays 0.
- R8: The complement output is always the inverse of the true output.
- R9: The true output stays high for exactly the width value sampled on the cycle the pulse starts. Width 0 gives one cycle, and later changes of the width input do not affect a running pulse.
- R10: Synchronous reset drives the true output to 0. After reset is released, input levels that were already present cause no pulse.
- R11: The two channels are independent. Activity on one channel leaves the other channel's outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_lo_n_i | input | N_CHAN | Active-low trigger line per channel |
| trig_hi_i | input | N_CHAN | Active-high trigger line per channel |
| clr_n_i | input | N_CHAN | Active-low clear per channel |
| width_i | input | N_CHAN x W | Pulse length in cycles per channel |
| pulse_o | output | N_CHAN | True output per channel |
| pulse_n_o | output | N_CHAN | Complement output per channel |

## Verification
The hardest situation to reach is the clear-release trigger. It needs a fixed order of events: clear goes low, the high trigger rises while clear stays low, and clear is released with the low trigger already low. The negative cases, where the high trigger rose too early or fell again before release, need equally careful ordering. The stimulus table builds this order step by step, holding each step long enough to pass the synchroniser, and it includes both the cancelled-record case and the accepted case. The directed tests then count every high cycle of a pulse while trigger edges and width changes are injected in the middle of it.

// File: rtl/os_pkg.sv
package os_pkg;

    localparam int IDX_LO  = 0;
    localparam int IDX_HI  = 1;
    localparam int IDX_CLR = 2;
    localparam int N_LINES = 3;

    typedef struct packed {
        logic lo_fall;
        logic hi_rise;
        logic hi_fall;
        logic clr_rise;
    } edges_t;

endpackage

// File: rtl/os_sync.sv
module os_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    typedef struct packed {
        logic [N-1:0] stage1;
        logic [N-1:0] stage2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.stage1 = din;
            st_d.stage2 = din;
        end else begin
            st_d.stage1 = din;
            st_d.stage2 = st_q.stage1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = st_q.stage2;

endmodule

// File: rtl/os_edge.sv
module os_edge
    import os_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] lvl_i,
    input  logic [N_LINES-1:0] seed_i,
    output edges_t             edges_o
);

    logic [N_LINES-1:0] hist_d, hist_q;
    edges_t             ed;

    always_comb begin
        hist_d = rst ? seed_i : lvl_i;
        ed.lo_fall  = hist_q[IDX_LO]  & ~lvl_i[IDX_LO];
        ed.hi_rise  = ~hist_q[IDX_HI] &  lvl_i[IDX_HI];
        ed.hi_fall  = hist_q[IDX_HI]  & ~lvl_i[IDX_HI];
        ed.clr_rise = ~hist_q[IDX_CLR] & lvl_i[IDX_CLR];
        if (rst) begin
            ed = '0;
        end
    end

    always_ff @(posedge clk) begin
        hist_q <= hist_d;
    end

    assign edges_o = ed;

endmodule

// File: rtl/os_channel.sv
module os_channel
    import os_pkg::*;
#(
    parameter int W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] lvl_i,
    input  edges_t             edges_i,
    input  logic [W-1:0]       width_i,
    output logic               q_o,
    output logic               qn_o
);

    typedef struct packed {
        logic         active;
        logic [W-1:0] cnt;
        logic         armed;
    } chan_t;

    chan_t st_d, st_q;

    logic lo_s, hi_s, clr_s;
    logic fire_lo, fire_hi, fire_clr, fire;
    logic [W-1:0] load_val;

    always_comb begin
        lo_s  = lvl_i[IDX_LO];
        hi_s  = lvl_i[IDX_HI];
        clr_s = lvl_i[IDX_CLR];

        fire_lo  = clr_s & edges_i.lo_fall & hi_s;
        fire_hi  = clr_s & edges_i.hi_rise & ~lo_s;
        fire_clr = edges_i.clr_rise & ~lo_s & hi_s & st_q.armed;
        fire     = fire_lo | fire_hi | fire_clr;

        load_val = (width_i == '0) ? '0 : width_i - 1'b1;

        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else if (!clr_s) begin
            st_d.active = 1'b0;
            st_d.cnt    = '0;
            if (edges_i.hi_rise) begin
                st_d.armed = 1'b1;
            end else if (edges_i.hi_fall) begin
                st_d.armed = 1'b0;
            end
        end else if (st_q.active) begin
            if (st_q.cnt == '0) begin
                st_d.active = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
            if (edges_i.hi_fall) begin
                st_d.armed = 1'b0;
            end
        end else if (fire) begin
            st_d.active = 1'b1;
            st_d.cnt    = load_val;
            st_d.armed  = 1'b0;
        end else if (edges_i.hi_fall) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q_o  = st_q.active;
    assign qn_o = ~st_q.active;

endmodule

// File: rtl/dual_oneshot.sv
module dual_oneshot
    import os_pkg::*;
#(
    parameter int N_CHAN = 2,
    parameter int W      = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_CHAN-1:0]       trig_lo_n_i,
    input  logic [N_CHAN-1:0]       trig_hi_i,
    input  logic [N_CHAN-1:0]       clr_n_i,
    input  logic [N_CHAN-1:0][W-1:0] width_i,
    output logic [N_CHAN-1:0]       pulse_o,
    output logic [N_CHAN-1:0]       pulse_n_o
);

    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        logic [N_LINES-1:0] raw;
        logic [N_LINES-1:0] lvl;
        edges_t             ed;

        always_comb begin
            raw          = '0;
            raw[IDX_LO]  = trig_lo_n_i[g];
            raw[IDX_HI]  = trig_hi_i[g];
            raw[IDX_CLR] = clr_n_i[g];
        end

        os_sync #(.N(N_LINES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (raw),
            .dout (lvl)
        );

        os_edge u_edge (
            .clk     (clk),
            .rst     (rst),
            .lvl_i   (lvl),
            .seed_i  (raw),
            .edges_o (ed)
        );

        os_channel #(.W(W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .lvl_i   (lvl),
            .edges_i (ed),
            .width_i (width_i[g]),
            .q_o     (pulse_o[g]),
            .qn_o    (pulse_n_o[g])
        );
    end

endmodule

// File: rtl/os_check.sv
module os_check #(
    parameter int N_CHAN = 2,
    parameter int W      = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic [N_CHAN-1:0]        trig_lo_n_i,
    input logic [N_CHAN-1:0]        trig_hi_i,
    input logic [N_CHAN-1:0]        clr_n_i,
    input logic [N_CHAN-1:0][W-1:0] width_i,
    input logic [N_CHAN-1:0]        pulse_o,
    input logic [N_CHAN-1:0]        pulse_n_o
);

    for (genvar g = 0; g < N_CHAN; g++) begin : g_chk
        logic [W:0] run_q;
        logic [W:0] wlat_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                run_q  <= '0;
                wlat_q <= {{W{1'b0}}, 1'b1};
            end else begin
                run_q <= pulse_o[g] ? run_q + 1'b1 : '0;
                if (!pulse_o[g]) begin
                    wlat_q <= (width_i[g] == '0) ? {{W{1'b0}}, 1'b1} : {1'b0, width_i[g]};
                end
            end
        end

        // R3 and R8: clear seen low holds true output low, complement high
        p_clear_hold_r3: assert property (@(posedge clk) disable iff (rst)
            !$past(clr_n_i[g], 2) |=> (!pulse_o[g] && pulse_n_o[g]));

        // R7: a trigger line parked in its blocking level prevents a start
        p_no_start_r7: assert property (@(posedge clk) disable iff (rst)
            (!pulse_o[g] && (($past(trig_lo_n_i[g], 2) && $past(trig_lo_n_i[g], 3)) ||
                             (!$past(trig_hi_i[g], 2) && !$past(trig_hi_i[g], 3))))
            |=> !pulse_o[g]);

        // R9: a pulse never outlasts the width captured at its start
        p_len_max_r9: assert property (@(posedge clk) disable iff (rst)
            pulse_o[g] |-> (run_q < wlat_q));

        // R6: with clear high, a pulse does not end before its length
        p_no_early_end_r6: assert property (@(posedge clk) disable iff (rst)
            (pulse_o[g] && ((run_q + 1'b1) < wlat_q) &&
             $past(clr_n_i[g], 1) && $past(clr_n_i[g], 2)) |=> pulse_o[g]);
    end

endmodule

bind dual_oneshot os_check #(.N_CHAN(N_CHAN), .W(W)) u_os_check (
    .clk         (clk),
    .rst         (rst),
    .trig_lo_n_i (trig_lo_n_i),
    .trig_hi_i   (trig_hi_i),
    .clr_n_i     (clr_n_i),
    .width_i     (width_i),
    .pulse_o     (pulse_o),
    .pulse_n_o   (pulse_n_o)
);

// File: tb/sim_dual_oneshot.sv
module sim_dual_oneshot;

    localparam int CLK_P = 10;
    localparam int NV    = 24;
    localparam int STEP  = 6;

    logic             clk = 1'b0;
    logic             rst;
    logic [1:0]       a, b, c;
    logic [1:0][15:0] wid;
    logic [1:0]       q, qn;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dual_oneshot #(.N_CHAN(2), .W(16)) u0 (
        .clk         (clk),
        .rst         (rst),
        .trig_lo_n_i (a),
        .trig_hi_i   (b),
        .clr_n_i     (c),
        .width_i     (wid),
        .pulse_o     (q),
        .pulse_n_o   (qn)
    );

    // {tag, a[1:0], b[1:0], c[1:0], expected q[1:0]}, bit 0 is channel 0
    localparam logic [11:0] VEC [NV] = '{
        {4'd7,  8'b11_01_11_00},  // R7 ch0 hi rises, lo held high
        {4'd1,  8'b10_01_11_01},  // R1 ch0 lo falls, hi high
        {4'd6,  8'b11_01_11_01},  // R6 lo rises during pulse
        {4'd6,  8'b10_01_11_01},  // R6 lo falls during pulse
        {4'd4,  8'b10_01_10_01 & 8'b11_11_11_00}, // R4 ch0 clear cuts pulse
        {4'd5,  8'b10_01_11_00},  // R5 release without record
        {4'd7,  8'b00_01_11_00},  // R7 ch1 lo low, hi held low
        {4'd2,  8'b00_11_11_10},  // R2 ch1 hi rises, lo low
        {4'd3,  8'b00_11_01_00},  // R3 ch1 clear low
        {4'd3,  8'b00_01_01_00},  // R3 ch1 hi falls under clear
        {4'd3,  8'b00_11_01_00},  // R3 ch1 hi rises under clear
        {4'd5,  8'b00_11_11_10},  // R5 ch1 release with record
        {4'd11, 8'b00_11_10_10},  // R11 ch0 clear, ch1 keeps pulse
        {4'd11, 8'b00_10_10_10},  // R11
        {4'd3,  8'b00_11_10_10},  // R3 ch0 hi rises under clear
        {4'd5,  8'b00_10_10_10},  // R5 hi falls cancels record
        {4'd5,  8'b00_10_11_10},  // R5 release with hi low
        {4'd2,  8'b00_11_11_11},  // R2 ch0 hi rises, lo low
        {4'd3,  8'b00_11_00_00},  // R3 both cleared
        {4'd5,  8'b00_11_11_00},  // R5 no records held
        {4'd3,  8'b00_11_10_00},  // R3 ch0 clear low
        {4'd3,  8'b00_10_10_00},  // R3 ch0 hi falls
        {4'd3,  8'b00_11_10_00},  // R3 ch0 hi rises, record set
        {4'd5,  8'b00_11_11_01}   // R5 ch0 release starts pulse
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ticks(3);
        rst = 1'b0;
    endtask

    // trigger channel 0 from its low line and count high cycles
    task automatic measure(input int w, input bit disturb, input bit rewidth, output int cnt);
        a[0] = 1'b1; b[0] = 1'b1; c[0] = 1'b1;
        wid[0] = w[15:0];
        ticks(6);
        a[0] = 1'b0;
        cnt = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            check(qn[0] == ~q[0], "R8", qn[0], ~q[0]);
            if (q[0]) begin
                cnt++;
                if (disturb && cnt == 2) a[0] = 1'b1;
                if (disturb && cnt == 4) a[0] = 1'b0;
                if (disturb && cnt == 5) b[0] = 1'b0;
                if (disturb && cnt == 6) b[0] = 1'b1;
                if (rewidth && cnt == 2) wid[0] = 16'd40;
            end else if (cnt > 0) begin
                break;
            end
        end
        ticks(6);
        check(q[0] == 1'b0, "R6 no restart", q[0], 0);
        check(q[1] == 1'b0, "R11 quiet ch1", q[1], 0);
    endtask

    initial begin
        int n;
        a = 2'b00; b = 2'b11; c = 2'b11;
        wid[0] = 16'd3; wid[1] = 16'd3;
        rst = 1'b1;
        ticks(3);
        check(q == 2'b00, "R10 reset q", q, 0);
        check(qn == 2'b11, "R10 reset qn", qn, 3);
        rst = 1'b0;
        ticks(8);
        check(q == 2'b00, "R10 no start-up pulse", q, 0);

        a = 2'b11; b = 2'b00; c = 2'b11;
        wid[0] = 16'd200; wid[1] = 16'd200;
        ticks(STEP);
        check(q == 2'b00, "R10 idle", q, 0);

        for (int v = 0; v < NV; v++) begin
            a = VEC[v][7:6];
            b = VEC[v][5:4];
            c = (v == 4) ? 2'b10 : VEC[v][3:2];
            ticks(STEP);
            checks++;
            if (q !== VEC[v][1:0] || qn !== ~VEC[v][1:0]) begin
                fails++;
                $display("FAIL R%0d step %0d actual=%b expected=%b", VEC[v][11:8], v, q, VEC[v][1:0]);
            end
        end

        do_reset();
        a = 2'b11; b = 2'b11; c = 2'b11;
        ticks(6);

        // R1 latency: high after the third edge
        wid[0] = 16'd4;
        a[0] = 1'b0;
        ticks(2);
        check(q[0] == 1'b0, "R1 not before third edge", q[0], 0);
        ticks(1);
        check(q[0] == 1'b1, "R1 high after third edge", q[0], 1);
        ticks(10);

        measure(5, 1'b0, 1'b0, n);
        check(n == 5, "R9 width 5", n, 5);
        measure(0, 1'b0, 1'b0, n);
        check(n == 1, "R9 width 0", n, 1);
        measure(1, 1'b0, 1'b0, n);
        check(n == 1, "R9 width 1", n, 1);
        measure(12, 1'b1, 1'b0, n);
        check(n == 12, "R6 edges during pulse", n, 12);
        measure(6, 1'b0, 1'b1, n);
        check(n == 6, "R9 width change mid-pulse", n, 6);

        // R4 clear latency during a long pulse
        a[0] = 1'b1; b[0] = 1'b1; c[0] = 1'b1;
        wid[0] = 16'd100;
        ticks(6);
        a[0] = 1'b0;
        ticks(10);
        check(q[0] == 1'b1, "R4 pulse running", q[0], 1);
        c[0] = 1'b0;
        ticks(2);
        check(q[0] == 1'b1, "R4 before third edge", q[0], 1);
        ticks(1);
        check(q[0] == 1'b0, "R4 cut after third edge", q[0], 0);
        check(qn[0] == 1'b1, "R8 complement after cut", qn[0], 1);
        c[0] = 1'b1;
        ticks(8);
        check(q[0] == 1'b0, "R5 release without record", q[0], 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule